// File: doc/BRIEF.md
# Processor Restart and Write-back Controller

This block sits between a packet store and a small 8-bit embedded processor that works on stored packets. The store path fills a ring of data banks with incoming data packets, one packet per bank. Whenever the bank at the read pointer holds a packet, the controller restarts the processor by raising its interrupt input for two clock cycles. Just before that restart it decides which of two program banks the processor runs from. The bank changes only if a freshly loaded program is waiting; otherwise the processor keeps the program it already has.

The processor reports that it has finished with a packet by writing to one reserved output port ID. The controller does not send the packet at once. It waits until the store path is no longer writing a new incoming data packet. It then reads the packet out of data memory, one word per cycle, and presents it on a transmit stream. On the way out it exchanges the source and destination IPv4 addresses and the two halves of the UDP port word, so the packet goes back to its sender. Once the last word has been read, the bank is freed and the read pointer moves on.

Program packets take a separate path. They are echoed back to the sender with the same address and port exchange and no other change. This path has a fixed latency of two cycles.

Top module: `cpu_restart_wb_ctrl`

## Requirements
- R1: A restart holds `cpu_irq_o` high for exactly two consecutive cycles. A restart is issued only when the bank at the read pointer holds a stored data packet; with no packet pending, `cpu_irq_o` stays low.
- R2: If no `prog_loaded_i` pulse has arrived since the last restart, `prog_bank_o` keeps its value across the next restart.
- R3: If a `prog_loaded_i` pulse has arrived since the last restart, `prog_bank_o` toggles in the same cycle that `cpu_irq_o` rises. It changes at no other time.
- R4: The processor marks the current data bank finished by asserting `cpu_wr_strobe_i` with `cpu_port_id_i` equal to `DONE_PORT` (default 8'hF0) after the restart pulse has ended. A write to any other port ID has no effect, and so does a write made while idle or during the pulse.
- R5: Write-back (`mem_rd_en_o`) starts only in a cycle after the bank is finished and `store_busy_i` is low. While `store_busy_i` stays high, no word is read or sent.
- R6: Write-back reads one word per cycle at address {bank, word} and sends `PKT_WORDS` words in order, one cycle after each read. Word 3 (source IPv4) and word 4 (destination IPv4) are exchanged. Word 5 goes out with its 16-bit halves swapped (the UDP ports). `tx_last_o` marks only the final word.
- R7: Once a bank has been written back it is released, and `data_bank_o` advances to the next bank, wrapping modulo `NUM_BANKS`. A bank already pending there is restarted without further stimulus.
- R8: Echo words arrive on consecutive cycles and leave two cycles later in the same order. Echo words 3 and 4 are exchanged, echo word 5 has its halves swapped, and `echo_last_o` follows the input last flag.
- R9: After reset, `cpu_irq_o`, `prog_bank_o`, `data_bank_o`, `mem_rd_en_o`, `tx_valid_o` and `echo_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_stored_i | input | 1 | Pulse: store path finished writing a data packet into the next bank |
| store_busy_i | input | 1 | Store path is writing an incoming data packet (grant held) |
| prog_loaded_i | input | 1 | Pulse: a new program has been written into the inactive program bank |
| cpu_wr_strobe_i | input | 1 | Processor output-write strobe |
| cpu_port_id_i | input | 8 | Processor output port ID |
| cpu_irq_o | output | 1 | Processor interrupt (restart) |
| prog_bank_o | output | 1 | Active program bank |
| data_bank_o | output | BANK_W | Data bank the processor works on |
| mem_rd_en_o | output | 1 | Data memory read enable |
| mem_rd_addr_o | output | BANK_W+WORD_W | Data memory read address {bank, word} |
| mem_rd_data_i | input | 32 | Data memory read word, one cycle after the read |
| tx_valid_o | output | 1 | Write-back word valid |
| tx_data_o | output | 32 | Write-back word |
| tx_last_o | output | 1 | Final write-back word |
| echo_in_valid_i | input | 1 | Program packet word valid |
| echo_in_data_i | input | 32 | Program packet word |
| echo_in_last_i | input | 1 | Final program packet word |
| echo_valid_o | output | 1 | Echo word valid |
| echo_data_o | output | 32 | Echo word |
| echo_last_o | output | 1 | Final echo word |

## Verification
The assertions check the timing rules on every cycle:
- the interrupt pulse is exactly two cycles long;
- the program bank changes only when the interrupt rises;
- no memory read starts while the store path holds its grant or during the pulse;
- every transmit and echo word lines up with the stimulus that caused it.

Only the bench scenarios can show the data-dependent outcomes. These are whether a program was pending at each restart, the exact word order after the address and port exchange, and the wrap of the bank pointer across four queued packets. A behavioural model in the bench covers these, and the bench also checks that a write to the wrong port is ignored.

// File: rtl/rwc_pkg.sv
// Shared types and helpers for the restart and write-back controller.
package rwc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IRQ1,
        ST_IRQ2,
        ST_RUN,
        ST_WB
    } seq_state_t;

    // Exchange the two 16-bit halves of a word (UDP source/destination ports).
    function automatic logic [31:0] swap_halves(input logic [31:0] w);
        return {w[15:0], w[31:16]};
    endfunction

endpackage

// File: rtl/rwc_bank_track.sv
// Tracks which data banks hold a stored packet and which the processor has
// finished. Assumes the store path never writes into a bank that is still
// valid (it stops when the ring is full).
module rwc_bank_track #(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stored_i,
    input  logic              done_set_i,
    input  logic              release_i,
    output logic [BANK_W-1:0] rd_ptr_o,
    output logic              cur_valid_o,
    output logic              cur_done_o
);

    logic [BANK_W-1:0]    wr_ptr;
    logic [BANK_W-1:0]    rd_ptr;
    logic [NUM_BANKS-1:0] valid_q;
    logic [NUM_BANKS-1:0] done_q;

    // Step a ring pointer by one, wrapping at NUM_BANKS.
    function automatic logic [BANK_W-1:0] step(input logic [BANK_W-1:0] p);
        return (p == BANK_W'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance the write pointer on each stored packet, the read pointer on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (stored_i)  wr_ptr <= step(wr_ptr);
            if (release_i) rd_ptr <= step(rd_ptr);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Per-bank valid and done flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[b] <= 1'b0;
                done_q[b]  <= 1'b0;
            end else begin
                if (stored_i && wr_ptr == BANK_W'(b))
                    valid_q[b] <= 1'b1;
                else if (release_i && rd_ptr == BANK_W'(b))
                    valid_q[b] <= 1'b0;
                if (done_set_i && rd_ptr == BANK_W'(b))
                    done_q[b] <= 1'b1;
                else if (release_i && rd_ptr == BANK_W'(b))
                    done_q[b] <= 1'b0;
            end
        end
    end

    assign rd_ptr_o    = rd_ptr;
    assign cur_valid_o = valid_q[rd_ptr];
    assign cur_done_o  = done_q[rd_ptr];

endmodule

// File: rtl/rwc_sequencer.sv
// Restart and write-back sequencer. It raises the interrupt for two cycles,
// flips the program bank when a new program is pending, waits for the done
// flag and an idle store path, then issues one memory read per cycle with
// the IPv4 source and destination words exchanged.
// Assumes DST IP word = SRC IP word + 1.
module rwc_sequencer
    import rwc_pkg::*;
#(
    parameter  int         PKT_WORDS   = 16,
    parameter  int         SRC_IP_WORD = 3,
    parameter  logic [7:0] DONE_PORT   = 8'hF0,
    localparam int         WORD_W      = $clog2(PKT_WORDS),
    localparam int         DST_IP_WORD = SRC_IP_WORD + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_loaded_i,
    input  logic              cpu_wr_strobe_i,
    input  logic [7:0]        cpu_port_id_i,
    input  logic              store_busy_i,
    input  logic              cur_valid_i,
    input  logic              cur_done_i,
    output logic              done_set_o,
    output logic              release_o,
    output logic              irq_o,
    output logic              prog_bank_o,
    output logic              rd_en_o,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [WORD_W-1:0] wb_idx_o
);

    seq_state_t        state;
    logic              pend;
    logic              bank;
    logic [WORD_W-1:0] cnt;
    logic              take;
    logic              last_word;

    assign take      = (state == ST_IDLE) && cur_valid_i && pend;
    assign last_word = (cnt == WORD_W'(PKT_WORDS - 1));

    // Main state machine with the program bank and the pending-program flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
            bank  <= 1'b0;
            cnt   <= '0;
        end else begin
            pend <= (pend && !take) || prog_loaded_i;
            case (state)
                ST_IDLE: if (cur_valid_i) begin
                    state <= ST_IRQ1;
                    if (pend) bank <= ~bank;
                end
                ST_IRQ1: state <= ST_IRQ2;
                ST_IRQ2: state <= ST_RUN;
                ST_RUN: if (cur_done_i && !store_busy_i) begin
                    state <= ST_WB;
                    cnt   <= '0;
                end
                ST_WB: if (last_word) state <= ST_IDLE;
                       else           cnt   <= cnt + 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Map the outgoing word index to the stored word so the IP addresses trade places.
    always_comb begin
        rd_word_o = cnt;
        if (cnt == WORD_W'(SRC_IP_WORD))      rd_word_o = WORD_W'(DST_IP_WORD);
        else if (cnt == WORD_W'(DST_IP_WORD)) rd_word_o = WORD_W'(SRC_IP_WORD);
    end

    assign done_set_o  = (state == ST_RUN) && cpu_wr_strobe_i && (cpu_port_id_i == DONE_PORT);
    assign release_o   = (state == ST_WB) && last_word;
    assign irq_o       = (state == ST_IRQ1) || (state == ST_IRQ2);
    assign prog_bank_o = bank;
    assign rd_en_o     = (state == ST_WB);
    assign wb_idx_o    = cnt;

endmodule

// File: rtl/rwc_tx_format.sv
// Turns memory read data (one-cycle latency) into the transmit stream and
// swaps the UDP port halves on the port word.
module rwc_tx_format
    import rwc_pkg::*;
#(
    parameter  int PKT_WORDS = 16,
    parameter  int PORT_WORD = 5,
    localparam int WORD_W    = $clog2(PKT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [WORD_W-1:0] wb_idx_i,
    input  logic [31:0]       mem_data_i,
    output logic              tx_valid_o,
    output logic [31:0]       tx_data_o,
    output logic              tx_last_o
);

    logic              vld_q;
    logic [WORD_W-1:0] idx_q;

    // Delay the read strobe and word index to line up with the memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
        end else begin
            vld_q <= rd_en_i;
            idx_q <= wb_idx_i;
        end
    end

    assign tx_valid_o = vld_q;
    assign tx_data_o  = (idx_q == WORD_W'(PORT_WORD)) ? swap_halves(mem_data_i) : mem_data_i;
    assign tx_last_o  = vld_q && (idx_q == WORD_W'(PKT_WORDS - 1));

endmodule

// File: rtl/rwc_echo_swap.sv
// Echoes program packet words two cycles later. It exchanges the IPv4
// address words and swaps the port halves. Assumes packet words arrive on
// consecutive cycles and DST IP word = SRC IP word + 1.
module rwc_echo_swap
    import rwc_pkg::*;
#(
    parameter  int SRC_IP_WORD = 3,
    parameter  int PORT_WORD   = 5,
    parameter  int IDX_W       = 8,
    localparam int DST_IP_WORD = SRC_IP_WORD + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid_i,
    input  logic [31:0] in_data_i,
    input  logic        in_last_i,
    output logic        out_valid_o,
    output logic [31:0] out_data_o,
    output logic        out_last_o
);

    logic [IDX_W-1:0] in_idx;
    logic [IDX_W-1:0] s1_idx;
    logic             s1_vld;
    logic             s1_last;
    logic [31:0]      s1_data;
    logic [31:0]      s2_data;
    logic [31:0]      pick;

    // Word index within the incoming packet, saturating at its top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_idx <= '0;
        end else if (in_valid_i) begin
            if (in_last_i)        in_idx <= '0;
            else if (~&in_idx)    in_idx <= in_idx + 1'b1;
        end
    end

    // Two-deep delay line holding the previous two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_last <= 1'b0;
            s1_idx  <= '0;
            s1_data <= '0;
            s2_data <= '0;
        end else begin
            s1_vld  <= in_valid_i;
            s1_last <= in_valid_i && in_last_i;
            s1_idx  <= in_idx;
            s1_data <= in_data_i;
            s2_data <= s1_data;
        end
    end

    // Choose the word that belongs in the slot now leaving the first stage.
    always_comb begin
        pick = s1_data;
        if (s1_idx == IDX_W'(SRC_IP_WORD))      pick = in_data_i;
        else if (s1_idx == IDX_W'(DST_IP_WORD)) pick = s2_data;
        else if (s1_idx == IDX_W'(PORT_WORD))   pick = swap_halves(s1_data);
    end

    // Registered echo output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_last_o  <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= s1_vld;
            out_last_o  <= s1_last;
            out_data_o  <= pick;
        end
    end

endmodule

// File: rtl/cpu_restart_wb_ctrl.sv
// Top of the processor restart and write-back controller. It joins the
// bank tracker, the sequencer, the transmit formatter and the echo path.
// Assumes a data memory with one-cycle read latency.
module cpu_restart_wb_ctrl
    import rwc_pkg::*;
#(
    parameter  int         NUM_BANKS   = 4,
    parameter  int         PKT_WORDS   = 16,
    parameter  int         SRC_IP_WORD = 3,
    parameter  int         PORT_WORD   = 5,
    parameter  logic [7:0] DONE_PORT   = 8'hF0,
    localparam int         BANK_W      = $clog2(NUM_BANKS),
    localparam int         WORD_W      = $clog2(PKT_WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     data_stored_i,
    input  logic                     store_busy_i,
    input  logic                     prog_loaded_i,
    input  logic                     cpu_wr_strobe_i,
    input  logic [7:0]               cpu_port_id_i,
    output logic                     cpu_irq_o,
    output logic                     prog_bank_o,
    output logic [BANK_W-1:0]        data_bank_o,
    output logic                     mem_rd_en_o,
    output logic [BANK_W+WORD_W-1:0] mem_rd_addr_o,
    input  logic [31:0]              mem_rd_data_i,
    output logic                     tx_valid_o,
    output logic [31:0]              tx_data_o,
    output logic                     tx_last_o,
    input  logic                     echo_in_valid_i,
    input  logic [31:0]              echo_in_data_i,
    input  logic                     echo_in_last_i,
    output logic                     echo_valid_o,
    output logic [31:0]              echo_data_o,
    output logic                     echo_last_o
);

    logic              done_set;
    logic              release_b;
    logic              cur_valid;
    logic              cur_done;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wb_idx;

    rwc_bank_track #(.NUM_BANKS(NUM_BANKS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .stored_i   (data_stored_i),
        .done_set_i (done_set),
        .release_i  (release_b),
        .rd_ptr_o   (data_bank_o),
        .cur_valid_o(cur_valid),
        .cur_done_o (cur_done)
    );

    rwc_sequencer #(
        .PKT_WORDS  (PKT_WORDS),
        .SRC_IP_WORD(SRC_IP_WORD),
        .DONE_PORT  (DONE_PORT)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_loaded_i  (prog_loaded_i),
        .cpu_wr_strobe_i(cpu_wr_strobe_i),
        .cpu_port_id_i  (cpu_port_id_i),
        .store_busy_i   (store_busy_i),
        .cur_valid_i    (cur_valid),
        .cur_done_i     (cur_done),
        .done_set_o     (done_set),
        .release_o      (release_b),
        .irq_o          (cpu_irq_o),
        .prog_bank_o    (prog_bank_o),
        .rd_en_o        (mem_rd_en_o),
        .rd_word_o      (rd_word),
        .wb_idx_o       (wb_idx)
    );

    assign mem_rd_addr_o = {data_bank_o, rd_word};

    rwc_tx_format #(.PKT_WORDS(PKT_WORDS), .PORT_WORD(PORT_WORD)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (mem_rd_en_o),
        .wb_idx_i  (wb_idx),
        .mem_data_i(mem_rd_data_i),
        .tx_valid_o(tx_valid_o),
        .tx_data_o (tx_data_o),
        .tx_last_o (tx_last_o)
    );

    rwc_echo_swap #(.SRC_IP_WORD(SRC_IP_WORD), .PORT_WORD(PORT_WORD)) u_echo (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (echo_in_valid_i),
        .in_data_i  (echo_in_data_i),
        .in_last_i  (echo_in_last_i),
        .out_valid_o(echo_valid_o),
        .out_data_o (echo_data_o),
        .out_last_o (echo_last_o)
    );

endmodule

// File: rtl/rwc_checker.sv
// Timing properties of the controller, observed at its ports.
module rwc_checker (
    input logic clk,
    input logic rst_n,
    input logic store_busy_i,
    input logic cpu_irq_o,
    input logic prog_bank_o,
    input logic mem_rd_en_o,
    input logic tx_valid_o,
    input logic tx_last_o,
    input logic echo_in_valid_i,
    input logic echo_valid_o
);

    // R1
    irq_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq_o) |=> cpu_irq_o);

    // R1
    irq_two_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && $past(cpu_irq_o)) |=> !cpu_irq_o);

    // R3
    bank_flip_at_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_bank_o) |-> $rose(cpu_irq_o));

    // R5
    wb_store_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en_o) |-> !$past(store_busy_i));

    // R5
    no_read_in_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> !mem_rd_en_o);

    // R6
    tx_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(mem_rd_en_o));

    // R6
    last_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    // R8
    echo_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        echo_valid_o |-> $past(echo_in_valid_i, 2));

endmodule

bind cpu_restart_wb_ctrl rwc_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .store_busy_i   (store_busy_i),
    .cpu_irq_o      (cpu_irq_o),
    .prog_bank_o    (prog_bank_o),
    .mem_rd_en_o    (mem_rd_en_o),
    .tx_valid_o     (tx_valid_o),
    .tx_last_o      (tx_last_o),
    .echo_in_valid_i(echo_in_valid_i),
    .echo_valid_o   (echo_valid_o)
);

// File: tb/cpu_restart_wb_ctrl_tb.sv
module cpu_restart_wb_ctrl_tb;

    localparam int NB   = 4;
    localparam int PKT  = 16;
    localparam int BW   = 2;
    localparam int WW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_stored_i = 0, store_busy_i = 0, prog_loaded_i = 0;
    logic cpu_wr_strobe_i = 0;
    logic [7:0] cpu_port_id_i = 0;
    logic cpu_irq_o, prog_bank_o, mem_rd_en_o, tx_valid_o, tx_last_o;
    logic [BW-1:0] data_bank_o;
    logic [BW+WW-1:0] mem_rd_addr_o;
    logic [31:0] mem_rd_data_i = 0, tx_data_o;
    logic echo_in_valid_i = 0, echo_in_last_i = 0;
    logic [31:0] echo_in_data_i = 0, echo_data_o;
    logic echo_valid_o, echo_last_o;

    always #5 clk = ~clk;

    cpu_restart_wb_ctrl u_dut (.*);

    int total = 0, bad = 0;
    logic [31:0] mem [NB*PKT];

    // Behavioural memory with one-cycle read latency.
    always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_rd_addr_o];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[15:0], w[31:16]};
    endfunction

    // ---------------- reference model ----------------
    int m_st = 0, m_rd = 0, m_wr = 0, m_cnt = 0;
    bit m_prog = 0, m_pend = 0;
    bit m_valid [NB];
    bit m_done [NB];
    logic [31:0] exp_tx[$];
    bit          exp_tl[$];
    logic [31:0] exp_ec[$];
    bit          exp_el[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rd = 0; m_wr = 0; m_cnt = 0; m_prog = 0; m_pend = 0;
            foreach (m_valid[i]) begin m_valid[i] = 0; m_done[i] = 0; end
        end else begin
            int old_st;
            bit consumed;
            old_st = m_st;
            consumed = 0;
            case (m_st)
                0: if (m_valid[m_rd]) begin
                       if (m_pend) begin m_prog = !m_prog; consumed = 1; end
                       m_st = 1;
                   end
                1: m_st = 2;
                2: m_st = 3;
                3: if (m_done[m_rd] && !store_busy_i) begin
                       m_st = 4; m_cnt = 0;
                       for (int i = 0; i < PKT; i++) begin
                           int s;
                           logic [31:0] w;
                           s = (i == 3) ? 4 : (i == 4) ? 3 : i;
                           w = mem[m_rd*PKT + s];
                           exp_tx.push_back(i == 5 ? swp(w) : w);
                           exp_tl.push_back(i == PKT-1);
                       end
                   end
                4: if (m_cnt == PKT-1) begin
                       m_valid[m_rd] = 0; m_done[m_rd] = 0;
                       m_rd = (m_rd + 1) % NB; m_st = 0;
                   end else m_cnt++;
                default: m_st = 0;
            endcase
            if (old_st == 3 && cpu_wr_strobe_i && cpu_port_id_i == 8'hF0) m_done[m_rd] = 1;
            if (data_stored_i) begin m_valid[m_wr] = 1; m_wr = (m_wr + 1) % NB; end
            m_pend = (m_pend && !consumed) || prog_loaded_i;
        end
    end

    // Per-cycle comparison and stream counting, away from the active edge.
    int irq_cycles = 0, tx_seen = 0, echo_seen = 0;
    always @(negedge clk) if (rst_n) begin
        chk(cpu_irq_o == (m_st == 1 || m_st == 2), "R1 irq vs model", cpu_irq_o, (m_st == 1 || m_st == 2));
        chk(prog_bank_o == m_prog, "R3 prog bank vs model", prog_bank_o, m_prog);
        chk(data_bank_o == BW'(m_rd), "R7 data bank vs model", data_bank_o, m_rd);
        if (cpu_irq_o) irq_cycles++;
        if (tx_valid_o) begin
            tx_seen++;
            if (exp_tx.size() == 0) chk(0, "R6 unexpected tx word", tx_data_o, 0);
            else begin
                logic [31:0] e;
                bit el;
                e = exp_tx.pop_front();
                el = exp_tl.pop_front();
                chk(tx_data_o == e, "R6 tx data", tx_data_o, e);
                chk(tx_last_o == el, "R6 tx last", tx_last_o, el);
            end
        end
        if (echo_valid_o) begin
            echo_seen++;
            if (exp_ec.size() == 0) chk(0, "R8 unexpected echo word", echo_data_o, 0);
            else begin
                logic [31:0] e;
                bit el;
                e = exp_ec.pop_front();
                el = exp_el.pop_front();
                chk(echo_data_o == e, "R8 echo data", echo_data_o, e);
                chk(echo_last_o == el, "R8 echo last", echo_last_o, el);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int tb_wr = 0;
    task automatic store_pkt(input int id);
        for (int i = 0; i < PKT; i++)
            mem[tb_wr*PKT + i] = {8'(id), 8'(i), 16'hA5C3 ^ 16'(i * 37)};
        tb_wr = (tb_wr + 1) % NB;
        @(negedge clk); data_stored_i = 1;
        @(negedge clk); data_stored_i = 0;
    endtask

    task automatic cpu_write(input logic [7:0] port);
        @(negedge clk); cpu_wr_strobe_i = 1; cpu_port_id_i = port;
        @(negedge clk); cpu_wr_strobe_i = 0; cpu_port_id_i = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        int c0, t0;
        for (int i = 0; i < NB*PKT; i++) mem[i] = 0;
        wait_cycles(5);
        // R9 reset state
        chk(cpu_irq_o == 0 && mem_rd_en_o == 0 && tx_valid_o == 0, "R9 reset outputs", {cpu_irq_o, mem_rd_en_o, tx_valid_o}, 0);
        chk(prog_bank_o == 0 && data_bank_o == 0 && echo_valid_o == 0, "R9 reset banks", {prog_bank_o, data_bank_o, echo_valid_o}, 0);
        rst_n = 1;

        // R1 idle: nothing stored, no restart
        wait_cycles(10);
        chk(irq_cycles == 0, "R1 no restart when idle", irq_cycles, 0);

        // R1 pulse width, R2 bank kept
        store_pkt(1);
        wait_cycles(8);
        chk(irq_cycles == 2, "R1 two-cycle restart", irq_cycles, 2);
        chk(prog_bank_o == 0, "R2 bank kept", prog_bank_o, 0);

        // R4 wrong port ignored
        cpu_write(8'h11);
        wait_cycles(10);
        chk(tx_seen == 0 && mem_rd_en_o == 0, "R4 wrong port ignored", tx_seen, 0);

        // R5 store busy holds write-back
        store_busy_i = 1;
        cpu_write(8'hF0);
        wait_cycles(10);
        chk(tx_seen == 0, "R5 held while store busy", tx_seen, 0);
        store_busy_i = 0;
        wait_cycles(25);
        chk(tx_seen == 16, "R6 full packet sent", tx_seen, 16);
        chk(data_bank_o == 1, "R7 read pointer advanced", data_bank_o, 1);

        // R3 new program flips bank at next restart
        @(negedge clk); prog_loaded_i = 1;
        @(negedge clk); prog_loaded_i = 0;
        c0 = irq_cycles;
        chk(prog_bank_o == 0, "R3 no flip before restart", prog_bank_o, 0);
        store_pkt(2);
        wait_cycles(6);
        chk(irq_cycles == c0 + 2, "R1 second restart", irq_cycles, c0 + 2);
        chk(prog_bank_o == 1, "R3 flipped on restart", prog_bank_o, 1);
        cpu_write(8'hF0);
        wait_cycles(25);
        chk(tx_seen == 32, "R6 second packet", tx_seen, 32);

        // R7 two queued packets processed in turn, R2 bank unchanged
        store_pkt(3);
        store_pkt(4);
        wait_cycles(6);
        chk(prog_bank_o == 1, "R2 bank kept third restart", prog_bank_o, 1);
        cpu_write(8'hF0);
        wait_cycles(25);
        t0 = irq_cycles;
        chk(data_bank_o == 3, "R7 moved to queued bank", data_bank_o, 3);
        cpu_write(8'hF0);
        wait_cycles(25);
        chk(tx_seen == 64, "R7 both queued packets sent", tx_seen, 64);
        chk(data_bank_o == 0, "R7 pointer wrapped", data_bank_o, 0);
        chk(irq_cycles == t0, "R1 no restart with ring empty", irq_cycles, t0);

        // R8 echo path
        for (int i = 0; i < 10; i++) begin
            logic [31:0] w;
            int s;
            s = (i == 3) ? 4 : (i == 4) ? 3 : i;
            w = 32'hE000_0000 + 32'(s * 32'h0101_0011);
            exp_ec.push_back(i == 5 ? swp(w) : w);
            exp_el.push_back(i == 9);
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            echo_in_valid_i = 1;
            echo_in_data_i  = 32'hE000_0000 + 32'(i * 32'h0101_0011);
            echo_in_last_i  = (i == 9);
        end
        @(negedge clk); echo_in_valid_i = 0; echo_in_last_i = 0;
        wait_cycles(5);
        chk(echo_seen == 10, "R8 echo word count", echo_seen, 10);
        chk(exp_tx.size() == 0 && exp_ec.size() == 0, "R6 R8 queues drained", exp_tx.size() + exp_ec.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule